// File: doc/BRIEF.md
# Branch Target Predictor

This block sits beside the fetch stage and chooses the next fetch address in the same cycle that the current fetch address is presented. A small direct-mapped table is indexed by the word-address bits of the fetch PC. Each slot records whether it is in use, the complete address of the control instruction that filled it, the address that instruction last jumped to, and a two-bit saturating confidence counter. When the fetch PC matches an occupied slot exactly and the counter leans towards taken, the stored address is offered as the next PC. In every other case the sequential address PC+4 is offered.

Training comes from the execute stage once a control instruction has resolved. The pipeline returns the instruction's PC, the address it actually went to, whether it was taken, whether it really was a control instruction, and the next PC that fetch used for it. From these the block decides, in the same cycle, whether fetch went the wrong way and what address to restart from. The pipeline then discards the wrong-path instruction. Table changes made by a training beat are seen by lookups from the following cycle onwards. The training port is a single-cycle strobe and is never back-pressured: every beat with the valid bit set is taken in that cycle. No data stream crosses the block's edge, so no valid/ready pair is used.

Top module: `branch_target_predictor`

## Requirements
- R1: While reset is held, every slot is marked empty, so after reset each lookup reports no hit and a next PC of PC+4.
- R2: A lookup whose slot is empty, or whose stored address differs from the fetch PC in any bit, reports no hit and a next PC of PC+4. This includes a different PC that maps to the same slot.
- R3: On a hit, the next PC is the stored target when bit 1 of the counter is set (predict taken). When bit 1 is clear it is PC+4, and the hit flag is still raised.
- R4: The counter runs 0 (firmly not taken), 1, 2, 3 (firmly taken). A resolved taken beat on a hit slot adds one and stops at 3. A not-taken beat subtracts one and stops at 0. From 3 or 0 the predicted direction flips only after two consecutive wrong outcomes.
- R5: A taken control instruction that misses the table claims its slot. The slot stores its full PC, its target, and a counter of 2 (weakly taken), so the next lookup of that PC predicts the new target.
- R6: A not-taken control instruction that misses does not claim a slot. A beat flagged as not a control instruction leaves every slot unchanged.
- R7: The resolved next PC is the target when the beat is a taken control instruction, and PC+4 otherwise. It is driven on the redirect output during every valid beat. The mispredict output is raised in that same cycle exactly when this address differs from the next PC that fetch used.
- R8: On a hit that mispredicts with a taken outcome, the stored target is replaced. On any other hit only the counter changes.
- R9: The slot index is taken from PC bits [IDX_W+1:2]. PC bits [1:0] and the bits above the index take part only in the full-address match.
- R10: A lookup and a training beat in the same cycle see the table contents from before that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | PC_W | Fetch PC to look up |
| lk_hit | output | 1 | Fetch PC matched an occupied slot |
| lk_taken | output | 1 | Hit and counter predicts taken |
| lk_next_pc | output | PC_W | Predicted next fetch PC |
| upd_valid | input | 1 | Training beat present this cycle |
| upd_pc | input | PC_W | PC of the resolved instruction |
| upd_target | input | PC_W | Address it jumped to if taken |
| upd_taken | input | 1 | Instruction was taken |
| upd_is_ctrl | input | 1 | Instruction is a branch or jump |
| upd_pred_pc | input | PC_W | Next PC that fetch used after it |
| mispredict | output | 1 | Fetch followed the wrong path |
| redirect_pc | output | PC_W | Resolved next PC to restart fetch from |

## Verification
The hardest state to reach from the ports is a counter that must be walked to each end and back again. Only this walk shows that one wrong outcome from a firm state keeps the direction and a second one flips it. A second case, equally hard, is a slot being overwritten with a new target while an aliasing PC is looked up. The stimulus drives runs of training beats for a single branch PC that alternate between taken and not-taken outcomes. Between the beats it places lookups of that PC, of a PC that aliases to the same slot, and of the same PC with different low bits. It then issues a lookup and a training beat for the same PC in one cycle, to show that the lookup sees the table as it was before the beat.

// File: rtl/btp_pkg.sv
package btp_pkg;
  // Two-bit confidence state; the upper bit is the predicted direction.
  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'd0,
    CTR_WEAK_NT   = 2'd1,
    CTR_WEAK_T    = 2'd2,
    CTR_STRONG_T  = 2'd3
  } ctr_e;

  localparam int CTR_W = 2;
endpackage

// File: rtl/btp_sat_ctr.sv
module btp_sat_ctr
  import btp_pkg::*;
(
  input  ctr_e cur,
  input  logic taken,
  output ctr_e nxt
);
  always_comb begin
    case (cur)
      CTR_STRONG_NT: nxt = taken ? CTR_WEAK_NT  : CTR_STRONG_NT;
      CTR_WEAK_NT:   nxt = taken ? CTR_WEAK_T   : CTR_STRONG_NT;
      CTR_WEAK_T:    nxt = taken ? CTR_STRONG_T : CTR_WEAK_NT;
      default:       nxt = taken ? CTR_STRONG_T : CTR_WEAK_T;
    endcase
  end

  // R4: the counter holds at its ends
  always_comb begin
    if (taken && cur == CTR_STRONG_T)
      assert_sat_high_R4: assert (nxt == CTR_STRONG_T);
    if (!taken && cur == CTR_STRONG_NT)
      assert_sat_low_R4: assert (nxt == CTR_STRONG_NT);
  end
endmodule

// File: rtl/btp_store.sv
module btp_store #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int NRD   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
  output logic [NRD-1:0]             rd_valid,
  output logic [NRD-1:0][PC_W-1:0]   rd_tag,
  output logic [NRD-1:0][1:0]        rd_ctr,
  output logic [PC_W-1:0]            rd_tgt,
  input  logic                       wr_en,
  input  logic                       wr_alloc,
  input  logic                       wr_tgt_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [PC_W-1:0]            wr_tag,
  input  logic [PC_W-1:0]            wr_tgt,
  input  logic [1:0]                 wr_ctr
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] valid_q;
  logic [PC_W-1:0]  tag_q [DEPTH];
  logic [PC_W-1:0]  tgt_q [DEPTH];
  logic [1:0]       ctr_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n)
      valid_q <= '0;
    else if (wr_en && wr_alloc)
      valid_q[wr_idx] <= 1'b1;
  end

  // Payload needs no reset: an empty slot is never read as a hit.
  always_ff @(posedge clk) begin
    if (rst_n && wr_en) begin
      ctr_q[wr_idx] <= wr_ctr;
      if (wr_alloc)  tag_q[wr_idx] <= wr_tag;
      if (wr_tgt_en) tgt_q[wr_idx] <= wr_tgt;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_valid[p] = valid_q[rd_idx[p]];
    assign rd_tag[p]   = tag_q[rd_idx[p]];
    assign rd_ctr[p]   = ctr_q[rd_idx[p]];
  end
  assign rd_tgt = tgt_q[rd_idx[0]];

  // R1: reset empties the whole table
  assert_clear_on_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (valid_q == '0));

  // R5: an allocation leaves an occupied slot holding the full PC
  assert_alloc_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_alloc) |=> (valid_q[$past(wr_idx)] && (tag_q[$past(wr_idx)] == $past(wr_tag))));
endmodule

// File: rtl/btp_resolve.sv
module btp_resolve
  import btp_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_taken,
  input  logic            upd_is_ctrl,
  input  logic [PC_W-1:0] upd_pred_pc,
  input  logic            ent_valid,
  input  logic [PC_W-1:0] ent_tag,
  input  logic [1:0]      ent_ctr,
  output logic            mispredict,
  output logic [PC_W-1:0] redirect_pc,
  output logic            wr_en,
  output logic            wr_alloc,
  output logic            wr_tgt_en,
  output logic [1:0]      wr_ctr
);
  logic ent_hit;
  logic go_taken;
  ctr_e ctr_nxt;

  assign ent_hit  = ent_valid && (ent_tag == upd_pc);
  assign go_taken = upd_is_ctrl && upd_taken;

  btp_sat_ctr u_ctr (
    .cur   (ctr_e'(ent_ctr)),
    .taken (upd_taken),
    .nxt   (ctr_nxt)
  );

  always_comb begin
    redirect_pc = go_taken ? upd_target : upd_pc + PC_W'(4);
    mispredict  = upd_valid && (redirect_pc != upd_pred_pc);
    wr_en       = upd_valid && upd_is_ctrl && (ent_hit || upd_taken);
    wr_alloc    = !ent_hit;
    wr_tgt_en   = !ent_hit || (mispredict && upd_taken);
    wr_ctr      = ent_hit ? 2'(ctr_nxt) : 2'(CTR_WEAK_T);
  end

  // R6: only a taken control instruction may claim a slot
  always_comb begin
    if (wr_en && wr_alloc)
      assert_alloc_taken_R6: assert (upd_taken && upd_is_ctrl);
  end
endmodule

// File: rtl/branch_target_predictor.sv
module branch_target_predictor #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_hit,
  output logic            lk_taken,
  output logic [PC_W-1:0] lk_next_pc,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_taken,
  input  logic            upd_is_ctrl,
  input  logic [PC_W-1:0] upd_pred_pc,
  output logic            mispredict,
  output logic [PC_W-1:0] redirect_pc
);
  localparam int NRD     = 2;
  localparam int RD_LOOK = 0;
  localparam int RD_UPD  = 1;
  localparam int IDX_LO  = 2;
  localparam int IDX_HI  = IDX_W + IDX_LO - 1;

  logic [NRD-1:0][IDX_W-1:0] rd_idx;
  logic [NRD-1:0]            rd_valid;
  logic [NRD-1:0][PC_W-1:0]  rd_tag;
  logic [NRD-1:0][1:0]       rd_ctr;
  logic [PC_W-1:0]           rd_tgt;
  logic                      wr_en, wr_alloc, wr_tgt_en;
  logic [1:0]                wr_ctr;

  assign rd_idx[RD_LOOK] = lk_pc[IDX_HI:IDX_LO];
  assign rd_idx[RD_UPD]  = upd_pc[IDX_HI:IDX_LO];

  btp_store #(.PC_W(PC_W), .IDX_W(IDX_W), .NRD(NRD)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (rd_idx),
    .rd_valid  (rd_valid),
    .rd_tag    (rd_tag),
    .rd_ctr    (rd_ctr),
    .rd_tgt    (rd_tgt),
    .wr_en     (wr_en),
    .wr_alloc  (wr_alloc),
    .wr_tgt_en (wr_tgt_en),
    .wr_idx    (rd_idx[RD_UPD]),
    .wr_tag    (upd_pc),
    .wr_tgt    (upd_target),
    .wr_ctr    (wr_ctr)
  );

  btp_resolve #(.PC_W(PC_W)) u_resolve (
    .upd_valid   (upd_valid),
    .upd_pc      (upd_pc),
    .upd_target  (upd_target),
    .upd_taken   (upd_taken),
    .upd_is_ctrl (upd_is_ctrl),
    .upd_pred_pc (upd_pred_pc),
    .ent_valid   (rd_valid[RD_UPD]),
    .ent_tag     (rd_tag[RD_UPD]),
    .ent_ctr     (rd_ctr[RD_UPD]),
    .mispredict  (mispredict),
    .redirect_pc (redirect_pc),
    .wr_en       (wr_en),
    .wr_alloc    (wr_alloc),
    .wr_tgt_en   (wr_tgt_en),
    .wr_ctr      (wr_ctr)
  );

  // Fetch-side choice of next PC
  always_comb begin
    lk_hit     = rd_valid[RD_LOOK] && (rd_tag[RD_LOOK] == lk_pc);
    lk_taken   = lk_hit && rd_ctr[RD_LOOK][1];
    lk_next_pc = lk_taken ? rd_tgt : lk_pc + PC_W'(4);
  end

  // R2 / R3: without a taken prediction fetch falls through
  assert_fallthrough_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_taken |-> (lk_next_pc == lk_pc + PC_W'(4)));

  // R6: beats for non-control instructions never write the table
  assert_nonctrl_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_is_ctrl) |-> !wr_en);

  // R7: a raised mispredict always points somewhere new
  assert_redirect_differs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> (redirect_pc != upd_pred_pc));

  // R7: no mispredict outside a training beat
  assert_misp_needs_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> !mispredict);
endmodule

// File: tb/tb_branch_target_predictor.sv
module tb_branch_target_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W  = 32;
  localparam int IDX_W = 4;
  localparam int DEPTH = 1 << IDX_W;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic            lk_hit, lk_taken;
  logic [PC_W-1:0] lk_next_pc;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0, upd_target = '0, upd_pred_pc = '0;
  logic            upd_taken = 1'b0, upd_is_ctrl = 1'b0;
  logic            mispredict;
  logic [PC_W-1:0] redirect_pc;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_target_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_next_pc(lk_next_pc),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_target(upd_target),
    .upd_taken(upd_taken), .upd_is_ctrl(upd_is_ctrl), .upd_pred_pc(upd_pred_pc),
    .mispredict(mispredict), .redirect_pc(redirect_pc)
  );

  // Reference table built from the requirements
  logic            m_v   [DEPTH];
  logic [PC_W-1:0] m_tag [DEPTH];
  logic [PC_W-1:0] m_tgt [DEPTH];
  logic [1:0]      m_ctr [DEPTH];

  // Scoreboard queues, one entry per cycle
  logic [PC_W-1:0] q_next [$];
  logic            q_hit  [$];
  logic            q_uv   [$];
  logic            q_misp [$];
  logic [PC_W-1:0] q_redir[$];
  string           q_req  [$];

  function automatic logic [PC_W-1:0] m_look(input logic [PC_W-1:0] pc, output logic hit);
    int i;
    i = int'(pc[IDX_W+1:2]);
    hit = m_v[i] && (m_tag[i] == pc);
    if (hit && m_ctr[i][1]) return m_tgt[i];
    return pc + 32'd4;
  endfunction

  task automatic step(input logic [PC_W-1:0] lpc, input logic uv,
                      input logic [PC_W-1:0] upc, input logic [PC_W-1:0] utgt,
                      input logic utk, input logic uctl, input string req);
    logic h_l, h_u, e_misp;
    logic [PC_W-1:0] e_next, e_pred, e_res;
    int i;
    e_next = m_look(lpc, h_l);
    e_pred = m_look(upc, h_u);
    e_res  = (uctl && utk) ? utgt : upc + 32'd4;
    e_misp = uv && (e_res != e_pred);
    @(negedge clk);
    lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_target = utgt;
    upd_taken = utk; upd_is_ctrl = uctl; upd_pred_pc = e_pred;
    q_next.push_back(e_next); q_hit.push_back(h_l); q_uv.push_back(uv);
    q_misp.push_back(e_misp); q_redir.push_back(e_res); q_req.push_back(req);
    if (uv && uctl) begin
      i = int'(upc[IDX_W+1:2]);
      if (h_u) begin
        if (utk && m_ctr[i] != 2'd3) m_ctr[i] = m_ctr[i] + 2'd1;
        else if (!utk && m_ctr[i] != 2'd0) m_ctr[i] = m_ctr[i] - 2'd1;
        if (e_misp && utk) m_tgt[i] = utgt;
      end else if (utk) begin
        m_v[i] = 1'b1; m_tag[i] = upc; m_tgt[i] = utgt; m_ctr[i] = 2'd2;
      end
    end
  endtask

  task automatic look(input logic [PC_W-1:0] lpc, input string req);
    step(lpc, 1'b0, '0, '0, 1'b0, 1'b0, req);
  endtask

  task automatic train(input logic [PC_W-1:0] upc, input logic [PC_W-1:0] utgt,
                       input logic utk, input logic uctl, input string req);
    step('0, 1'b1, upc, utgt, utk, uctl, req);
  endtask

  // Monitor: compare a quarter period after the falling edge
  initial forever begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (q_next.size() > 0) begin
      logic [PC_W-1:0] e_next, e_redir;
      logic e_hit, e_uv, e_misp;
      string r;
      e_next = q_next.pop_front(); e_hit = q_hit.pop_front(); e_uv = q_uv.pop_front();
      e_misp = q_misp.pop_front(); e_redir = q_redir.pop_front(); r = q_req.pop_front();
      n_tests++;
      if (lk_next_pc !== e_next || lk_hit !== e_hit) begin
        n_fail++;
        $display("FAIL %s lookup pc=%h: next=%h hit=%b expected next=%h hit=%b",
                 r, lk_pc, lk_next_pc, lk_hit, e_next, e_hit);
      end
      if (e_uv) begin
        n_tests++;
        if (mispredict !== e_misp || redirect_pc !== e_redir) begin
          n_fail++;
          $display("FAIL %s train pc=%h: misp=%b redirect=%h expected misp=%b redirect=%h",
                   r, upd_pc, mispredict, redirect_pc, e_misp, e_redir);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_ctr[i] = 2'd0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: empty after reset
    look(32'h100, "R1");
    look(32'h13C, "R1");
    // R7 / R5: first taken branch mispredicts and claims a slot
    train(32'h100, 32'h300, 1'b1, 1'b1, "R7");
    look(32'h100, "R5");
    look(32'h100, "R3");
    // R2 / R9: aliases and low-bit differences miss
    look(32'h140, "R2");
    look(32'h104, "R2");
    look(32'h102, "R9");
    // R6: non-control beat changes nothing; untaken miss does not allocate
    train(32'h100, 32'hDEAD0, 1'b1, 1'b0, "R6");
    look(32'h100, "R6");
    train(32'h200, 32'h400, 1'b0, 1'b1, "R6");
    look(32'h200, "R6");
    // R4: walk the counter up, down and back
    train(32'h100, 32'h300, 1'b1, 1'b1, "R4");
    train(32'h100, 32'h300, 1'b0, 1'b1, "R4");
    look(32'h100, "R4");
    train(32'h100, 32'h300, 1'b0, 1'b1, "R4");
    look(32'h100, "R3");
    train(32'h100, 32'h300, 1'b0, 1'b1, "R4");
    train(32'h100, 32'h300, 1'b0, 1'b1, "R4");
    train(32'h100, 32'h300, 1'b1, 1'b1, "R4");
    look(32'h100, "R4");
    train(32'h100, 32'h300, 1'b1, 1'b1, "R4");
    look(32'h100, "R4");
    // R8: wrong target on a hit replaces it; a correct beat keeps it
    train(32'h100, 32'h500, 1'b1, 1'b1, "R8");
    look(32'h100, "R8");
    train(32'h100, 32'h500, 1'b1, 1'b1, "R8");
    train(32'h100, 32'h500, 1'b0, 1'b1, "R8");
    look(32'h100, "R8");
    // R9: highest index and its alias
    train(32'h3C, 32'h80, 1'b1, 1'b1, "R9");
    look(32'h3C, "R9");
    look(32'h7C, "R9");
    // R10: lookup and training of the same PC in one cycle
    step(32'h3C, 1'b1, 32'h3C, 32'h90, 1'b1, 1'b1, "R10");
    look(32'h3C, "R10");
    repeat (3) @(negedge clk);
    upd_valid = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule